// File: doc/BRIEF.md
# Four-Stage Shift/Load Register with JK First Stage

This block is a small register of four stages that share one clock. A mode-select input picks one of two operations for each rising clock edge. In shift mode every stage takes the value of its lower neighbour, so data moves from stage 0 toward the last stage. The new value of stage 0 comes from a JK-style serial pair. In load mode all stages are written at once from a parallel data bus.

The K input of the serial pair is active-low. Tying J and K to one wire therefore makes stage 0 a plain D input. An active-low clear forces every stage to zero at once, without waiting for a clock edge. The outputs are the true value of each stage and the inverted value of the last stage.

The register does not shift toward stage 0 by itself. The surrounding logic can get that behaviour by holding load mode and routing each stage output to the parallel input one position lower.

Top module: `jk_shift_reg`

## Requirements
- R1: With `shiftEn` = 1, each rising clock edge moves stage n-1 into stage n for every n from 1 to WIDTH-1.
- R2: With `shiftEn` = 0, each rising clock edge copies `parIn[n]` into stage n for every n.
- R3: In shift mode with `jIn` equal to `kBarIn`, stage 0 takes the value of `jIn`. With J=K=0 the result is 0, and with J=K=1 it is 1.
- R4: In shift mode with `jIn`=1 and `kBarIn`=0, stage 0 takes the inverse of its previous value.
- R5: In shift mode with `jIn`=0 and `kBarIn`=1, stage 0 keeps its previous value.
- R6: While `clearN` is 0, all stages read 0 at once, with or without a clock edge, and they stay 0 through clock edges.
- R7: `lastStageN` is always the inverse of stage WIDTH-1, which is `stageOut[3]` at the default width.
- R8: The stage outputs change only on a rising clock edge. Input changes between edges have no effect on them.
- R9: In load mode `jIn` and `kBarIn` have no effect on the stages. In shift mode `parIn` has no effect on the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock. Transfers happen on its rising edge. |
| clearN | input | 1 | Asynchronous clear, active low. |
| shiftEn | input | 1 | Mode select: 1 selects shift, 0 selects parallel load. |
| jIn | input | 1 | Serial J input to stage 0. |
| kBarIn | input | 1 | Serial K input to stage 0, active low. |
| parIn | input | WIDTH | Parallel load data. Bit n feeds stage n. |
| stageOut | output | WIDTH | True outputs of the stages. Bit n is stage n. |
| lastStageN | output | 1 | Inverted output of the last stage. |

## Verification
The assertions check on every clock edge that the shift moves data correctly, that a parallel load is exact, that stage 0 follows the set, reset, toggle and hold actions of the JK pair, and that the stages are zero whenever the clear is low.

Some behaviours cannot be written as single-edge properties, so only the bench scenarios show them. These are:
- the clear acting in the middle of a clock cycle;
- outputs staying unchanged while inputs move between edges;
- inputs that the current mode should ignore having no effect;
- the complementary output;
- shifting toward stage 0 through external feedback in load mode.

// File: rtl/jk_shift_pkg.sv
package jk_shift_pkg;

  // Action applied to stage 0 during a shift step
  typedef enum logic [1:0] {
    FIRST_RESET  = 2'd0,
    FIRST_SET    = 2'd1,
    FIRST_HOLD   = 2'd2,
    FIRST_TOGGLE = 2'd3
  } firstAction_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic         doShift;
    logic         doLoad;
    firstAction_e firstAct;
  } ctrlStrobes_t;

endpackage

// File: rtl/jk_shift_ctrl.sv
module jk_shift_ctrl
  import jk_shift_pkg::*;
(
  input  logic         shiftEn,
  input  logic         jIn,
  input  logic         kBarIn,
  output ctrlStrobes_t strobes
);

  firstAction_e actSel;

  // K is active low: J=0/Kb=0 reset, J=1/Kb=1 set, J=0/Kb=1 hold, J=1/Kb=0 toggle
  always_comb begin
    unique case ({jIn, kBarIn})
      2'b00:   actSel = FIRST_RESET;
      2'b11:   actSel = FIRST_SET;
      2'b01:   actSel = FIRST_HOLD;
      default: actSel = FIRST_TOGGLE;
    endcase
  end

  always_comb begin
    strobes.doShift  = shiftEn;
    strobes.doLoad   = ~shiftEn;
    strobes.firstAct = actSel;
  end

endmodule

// File: rtl/jk_shift_datapath.sv
module jk_shift_datapath
  import jk_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stage
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stageNext;
  logic             firstNext;

  always_comb begin
    unique case (strobes.firstAct)
      FIRST_RESET:  firstNext = 1'b0;
      FIRST_SET:    firstNext = 1'b1;
      FIRST_HOLD:   firstNext = stage[0];
      default:      firstNext = ~stage[0];
    endcase
  end

  always_comb begin
    stageNext[0] = strobes.doLoad ? parIn[0] : firstNext;
  end

  for (genvar n = 1; n <= LAST; n++) begin : gen_stage_mux
    always_comb begin
      stageNext[n] = strobes.doLoad ? parIn[n] : stage[n-1];
    end
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) begin
      stage <= '0;
    end else begin
      stage <= stageNext;
    end
  end

  // Shift moves each stage up one position
  assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doShift |=> stage[LAST:1] == $past(stage[LAST-1:0]));

  // Parallel load copies the data bus
  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!clearN)
    strobes.doLoad |=> stage == $past(parIn));

  // Reset and set actions of the JK pair
  assert_first_reset_R3: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doShift && strobes.firstAct == FIRST_RESET) |=> !stage[0]);

  assert_first_set_R3: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doShift && strobes.firstAct == FIRST_SET) |=> stage[0]);

  // Toggle action
  assert_first_toggle_R4: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doShift && strobes.firstAct == FIRST_TOGGLE) |=> stage[0] != $past(stage[0]));

  // Hold action
  assert_first_hold_R5: assert property (@(posedge clk) disable iff (!clearN)
    (strobes.doShift && strobes.firstAct == FIRST_HOLD) |=> $stable(stage[0]));

  // Clear keeps all stages at zero
  assert_clear_zero_R6: assert property (@(posedge clk)
    !clearN |-> stage == '0);

endmodule

// File: rtl/jk_shift_reg.sv
module jk_shift_reg
  import jk_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             shiftEn,
  input  logic             jIn,
  input  logic             kBarIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageOut,
  output logic             lastStageN
);

  ctrlStrobes_t     strobes;
  logic [WIDTH-1:0] stage;

  jk_shift_ctrl ctrl_i (
    .shiftEn (shiftEn),
    .jIn     (jIn),
    .kBarIn  (kBarIn),
    .strobes (strobes)
  );

  jk_shift_datapath #(.WIDTH(WIDTH)) data_i (
    .clk     (clk),
    .clearN  (clearN),
    .strobes (strobes),
    .parIn   (parIn),
    .stage   (stage)
  );

  assign stageOut   = stage;
  assign lastStageN = ~stage[WIDTH-1];

endmodule

// File: tb/jk_shift_reg_tb.sv
`timescale 1ns/1ps
module jk_shift_reg_tb_top;

  localparam int WIDTH = 4;

  logic             clk = 1'b0;
  logic             clearN = 1'b0;
  logic             shiftEn = 1'b0;
  logic             jIn = 1'b0;
  logic             kBarIn = 1'b0;
  logic [WIDTH-1:0] parIn = '0;
  logic [WIDTH-1:0] stageOut;
  logic             lastStageN;

  int checks = 0;
  int failures = 0;
  logic [WIDTH-1:0] refQ = '0;

  always #2.5 clk = ~clk;

  jk_shift_reg #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .clearN(clearN), .shiftEn(shiftEn), .jIn(jIn),
    .kBarIn(kBarIn), .parIn(parIn), .stageOut(stageOut), .lastStageN(lastStageN)
  );

  function automatic logic [WIDTH-1:0] modelNext(logic [WIDTH-1:0] q, logic sh,
                                                 logic j, logic kb, logic [WIDTH-1:0] p);
    logic f;
    if (!sh) return p;
    case ({j, kb})
      2'b00: f = 1'b0;
      2'b11: f = 1'b1;
      2'b01: f = q[0];
      default: f = ~q[0];
    endcase
    return {q[WIDTH-2:0], f};
  endfunction

  task automatic checkVal(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkComp(string tag);
    checkVal(tag, {{(WIDTH-1){1'b0}}, lastStageN}, {{(WIDTH-1){1'b0}}, ~refQ[WIDTH-1]});
  endtask

  // One clock edge with the current inputs; checks the model after it
  task automatic stepCheck(string tag);
    logic [WIDTH-1:0] e;
    e = modelNext(refQ, shiftEn, jIn, kBarIn, parIn);
    @(posedge clk);
    #1;
    refQ = e;
    checkVal(tag, stageOut, refQ);
  endtask

  task automatic testReset();
    #1;
    checkVal("R6 initial clear", stageOut, '0);
    checkVal("R7 complement under clear", {3'b0, lastStageN}, 4'b0001);
    @(posedge clk); #1;
    checkVal("R6 clear holds through edge", stageOut, '0);
    clearN = 1'b1;
    refQ = '0;
  endtask

  task automatic testLoad();
    shiftEn = 1'b0;
    parIn = 4'b1010; stepCheck("R2 load 1010"); checkComp("R7 after load 1010");
    parIn = 4'b0101; stepCheck("R2 load 0101"); checkComp("R7 after load 0101");
    parIn = 4'b1111; jIn = 1'b0; kBarIn = 1'b0;
    stepCheck("R9 load ignores J/K");
  endtask

  task automatic testJk();
    shiftEn = 1'b1;
    parIn = 4'b0000;
    jIn = 1'b0; kBarIn = 1'b0; stepCheck("R3 J=K=0 shift");
    checkVal("R1 shift moved", stageOut[3:1], 3'b111);
    jIn = 1'b1; kBarIn = 1'b1; stepCheck("R3 J=K=1 shift");
    jIn = 1'b1; kBarIn = 1'b0; stepCheck("R4 toggle 1");
    stepCheck("R4 toggle 2");
    stepCheck("R4 toggle 3");
    jIn = 1'b0; kBarIn = 1'b1; stepCheck("R5 hold 1");
    stepCheck("R5 hold 2");
    parIn = 4'b1001; stepCheck("R9 shift ignores parIn");
    checkComp("R7 after shifts");
  endtask

  task automatic testMixed();
    for (int i = 0; i < 24; i++) begin
      shiftEn = (i % 3) != 0;
      jIn = i[0];
      kBarIn = i[1] ^ i[2];
      parIn = 4'(i * 7 + 3);
      stepCheck(shiftEn ? "R1 mixed shift" : "R2 mixed load");
      checkComp("R7 mixed");
    end
  endtask

  task automatic testEdgeOnly();
    logic [WIDTH-1:0] held;
    shiftEn = 1'b0; parIn = 4'b0110; stepCheck("R2 pre-edge load");
    held = stageOut;
    parIn = 4'b1001; #1;
    shiftEn = 1'b1; jIn = 1'b1; kBarIn = 1'b0; #1;
    checkVal("R8 no change between edges", stageOut, held);
    shiftEn = 1'b0;
    @(negedge clk);
    parIn = 4'b0110;
  endtask

  task automatic testShiftLeft();
    shiftEn = 1'b0;
    parIn = 4'b1011; stepCheck("R2 shift-left seed");
    for (int i = 0; i < 5; i++) begin
      parIn = {1'(i & 1), stageOut[3:1]};
      stepCheck("R2 shift-left via feedback");
    end
  endtask

  task automatic testMidClear();
    shiftEn = 1'b0; parIn = 4'b1111; stepCheck("R2 load before clear");
    #0.7;
    clearN = 1'b0;
    #0.3;
    refQ = '0;
    checkVal("R6 mid-cycle clear", stageOut, '0);
    checkComp("R7 during clear");
    shiftEn = 1'b1; jIn = 1'b1; kBarIn = 1'b1;
    @(posedge clk); #1;
    checkVal("R6 clear dominates clock", stageOut, '0);
    clearN = 1'b1;
    stepCheck("R3 first shift after clear");
  endtask

  initial begin
    testReset();
    testLoad();
    testJk();
    testMixed();
    testEdgeOnly();
    testShiftLeft();
    testMidClear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule